// File: doc/BRIEF.md
# Serial Bitstream Configuration Loader

This block programs a downstream configurable device through a one-bit serial link. A host starts it with a single start pulse and a total byte count, then supplies the configuration bytes on a valid/ready stream. The block runs the device's two-phase reset handshake, shifting each byte out most significant bit first on a data pin that a serial clock qualifies. It keeps checking the device's error indication, and after the last byte it keeps clocking until the device reports completion.

A single run ends with exactly one of four results: success, handshake timeout, failure, or load error. The result stays on the outputs until the next accepted start. The serial clock phase width and every wait limit are set by parameters in system-clock cycles. The handshake limits and the completion limit default to 1,000,000 cycles, which is 10 ms at 100 MHz.

Pin senses used throughout: `prog_o`=1 means the device's reset/program request is asserted. `init_i`=1 means the device's init/error indication is asserted. `done_i`=1 means the device reports configuration complete.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset the block is idle. `busy_o`, `prog_o`, `cclk_o`, `din_o`, `byte_ready_o`, `ok_o`, `timeout_o`, `fail_o` and `crc_err_o` are all 0.
- R2: When `start_i` is sampled high while idle, `prog_o` goes to 1 from the next cycle and stays there until `init_i` is seen high. If `init_i` stays low for TIMEOUT_CYC cycles, the run ends with `timeout_o`=1.
- R3: Once `init_i` is seen high, `prog_o` returns to 0 and no byte is requested while `init_i` stays high. If `init_i` does not fall within TIMEOUT_CYC cycles, the run ends with `fail_o`=1.
- R4: Each byte is sent MSB first, one bit per `cclk_o` period. Each bit drives `cclk_o` low for exactly DIV cycles, with `din_o` updated at the falling edge, then high for at least DIV cycles. `din_o` never changes while `cclk_o` is high.
- R5: `byte_ready_o` is high only when the shifter is empty and fewer than the programmed count of bytes have been taken. Exactly that many bytes are consumed, in order.
- R6: Before each byte is taken, if `init_i`=1 while `done_i`=0, the run stops at once with `crc_err_o`=1 and no further byte is taken.
- R7: After the last byte, `din_o` is held at 1 and `cclk_o` keeps toggling (low DIV, high DIV) until `done_i`=1, which ends the run with `ok_o`=1.
- R8: If `done_i` does not rise within TIMEOUT_CYC cycles of the end of data, the run ends with `fail_o`=1, with `din_o` held at 1 throughout.
- R9: At most one result bit is set. Result bits hold while idle and clear only on the next accepted start. A `start_i` pulse while busy is ignored and does not change the run or the byte count.
- R10: A byte count of 0 skips the data phase and goes straight to the completion clocking of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| len_i | input | LEN_W | Number of bytes for the run, latched at start |
| byte_i | input | 8 | Configuration byte |
| byte_valid_i | input | 1 | Byte stream valid |
| byte_ready_o | output | 1 | Byte stream ready |
| prog_o | output | 1 | Program/reset request to device, 1 = asserted |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| init_i | input | 1 | Device init/error indication, 1 = asserted |
| done_i | input | 1 | Device configuration complete |
| busy_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run succeeded |
| timeout_o | output | 1 | Last run timed out waiting for init |
| fail_o | output | 1 | Last run failed (init did not clear, or no done) |
| crc_err_o | output | 1 | Last run stopped on a load error |

## Verification
The assertions assume that `init_i` and `done_i` are synchronous to `clk_i` and driven only between edges. They also assume `start_i` is a pulse, and that a device model which raises `done_i` never also raises `init_i` during completion clocking. The bench's device model changes `init_i` and `done_i` only on observed serial clock rises or at falling system-clock edges. Its byte feeder holds data steady until it sees ready. No scenario drives the error condition while the handshake is still in progress.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PROG,
    S_REL,
    S_FETCH,
    S_SHIFT,
    S_TAIL
  } ld_state_e;
endpackage

// File: rtl/cfg_tick_counter.sv
`timescale 1ns/1ps
module cfg_tick_counter #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || hit_o)  cnt_q <= '0;
    else if (en_i)            cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/cfg_bit_shifter.sv
`timescale 1ns/1ps
module cfg_bit_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_i,
  output logic             next_bit_o,
  output logic             last_o
);
  localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] sh_q;
  logic [IW-1:0]    idx_q;

  // bit that goes out after the current one
  assign next_bit_o = sh_q[WIDTH-2];
  assign last_o     = (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      idx_q <= IW'(WIDTH - 1);
    end else if (shift_i) begin
      sh_q  <= {sh_q[WIDTH-2:0], 1'b0};
      idx_q <= idx_q - IW'(1);
    end
  end
endmodule

// File: rtl/cfg_serial_loader.sv
`timescale 1ns/1ps
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned LEN_W       = 24,
  parameter int unsigned DIV         = 2,
  parameter int unsigned TIMEOUT_CYC = 1_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             prog_o,
  output logic             cclk_o,
  output logic             din_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             ok_o,
  output logic             timeout_o,
  output logic             fail_o,
  output logic             crc_err_o
);
  localparam int unsigned BW = 8;

  ld_state_e        state_q, state_d;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             cclk_q, din_q;
  logic             ok_q, tmo_q, fail_q, crc_q;
  logic             to_hit, ph_hit, sh_next, sh_last;
  logic             crc_trip, accept, ph_en, to_en, at_end;

  assign crc_trip     = init_i && !done_i;
  assign at_end       = (cnt_q == len_q);
  assign byte_ready_o = (state_q == S_FETCH) && !crc_trip && !at_end;
  assign accept       = byte_ready_o && byte_valid_i;
  assign ph_en        = (state_q == S_SHIFT) || (state_q == S_TAIL);
  assign to_en        = (state_q == S_PROG) || (state_q == S_REL) || (state_q == S_TAIL);

  assign prog_o    = (state_q == S_PROG);
  assign busy_o    = (state_q != S_IDLE);
  assign cclk_o    = cclk_q;
  assign din_o     = din_q;
  assign ok_o      = ok_q;
  assign timeout_o = tmo_q;
  assign fail_o    = fail_q;
  assign crc_err_o = crc_q;

  cfg_tick_counter #(.LIMIT(DIV)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!ph_en),
    .en_i  (ph_en),
    .hit_o (ph_hit)
  );

  cfg_tick_counter #(.LIMIT(TIMEOUT_CYC)) u_wait (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_d != state_q),
    .en_i  (to_en),
    .hit_o (to_hit)
  );

  cfg_bit_shifter #(.WIDTH(BW)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .data_i    (byte_i),
    .shift_i   ((state_q == S_SHIFT) && ph_hit && cclk_q && !sh_last),
    .next_bit_o(sh_next),
    .last_o    (sh_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_PROG;
      S_PROG:  if (init_i) state_d = S_REL;
               else if (to_hit) state_d = S_IDLE;
      S_REL:   if (!init_i) state_d = S_FETCH;
               else if (to_hit) state_d = S_IDLE;
      S_FETCH: if (crc_trip) state_d = S_IDLE;
               else if (at_end) state_d = S_TAIL;
               else if (accept) state_d = S_SHIFT;
      S_SHIFT: if (ph_hit && cclk_q && sh_last) state_d = S_FETCH;
      S_TAIL:  if (done_i || to_hit) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      cclk_q  <= 1'b0;
      din_q   <= 1'b0;
      ok_q    <= 1'b0;
      tmo_q   <= 1'b0;
      fail_q  <= 1'b0;
      crc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          len_q  <= len_i;
          cnt_q  <= '0;
          ok_q   <= 1'b0;
          tmo_q  <= 1'b0;
          fail_q <= 1'b0;
          crc_q  <= 1'b0;
        end
        S_PROG: if (!init_i && to_hit) tmo_q <= 1'b1;
        S_REL:  if (init_i && to_hit) fail_q <= 1'b1;
        S_FETCH: begin
          if (crc_trip) begin
            crc_q  <= 1'b1;
            cclk_q <= 1'b0;
            din_q  <= 1'b0;
          end else if (at_end) begin
            cclk_q <= 1'b0;
            din_q  <= 1'b1;
          end else if (accept) begin
            cnt_q  <= cnt_q + LEN_W'(1);
            cclk_q <= 1'b0;
            din_q  <= byte_i[BW-1];
          end
        end
        S_SHIFT: if (ph_hit) begin
          if (!cclk_q) begin
            cclk_q <= 1'b1;
          end else if (!sh_last) begin
            cclk_q <= 1'b0;
            din_q  <= sh_next;
          end
        end
        S_TAIL: begin
          if (done_i) begin
            ok_q   <= 1'b1;
            cclk_q <= 1'b0;
            din_q  <= 1'b0;
          end else if (to_hit) begin
            fail_q <= 1'b1;
            cclk_q <= 1'b0;
            din_q  <= 1'b0;
          end else if (ph_hit) begin
            cclk_q <= !cclk_q;
          end
        end
        default: ;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!prog_o && !byte_ready_o)); // R1
  AST_TMO_WITHOUT_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !$past(init_i)); // R2
  AST_DIN_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cclk_o && $past(cclk_o)) |-> $stable(din_o)); // R4
  AST_CRC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_err_o) |-> $past(init_i && !done_i)); // R6
  AST_OK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(done_i)); // R7
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_o, timeout_o, fail_o, crc_err_o})); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && !$past(start_i))
      |-> $stable({ok_o, timeout_o, fail_o, crc_err_o})); // R9
endmodule

// File: tb/cfg_serial_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_loader_tb_top;
  localparam int CLK_T = 10;
  localparam int DIV   = 2;
  localparam int TMO   = 200;
  localparam int LW    = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start_i = 1'b0, byte_valid_i = 1'b0, init_i = 1'b0, done_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic [7:0]    byte_i = '0;
  logic byte_ready_o, prog_o, cclk_o, din_o, busy_o, ok_o, timeout_o, fail_o, crc_err_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx [8];
  logic [7:0] rx_mem [8];
  logic [7:0] rx_sh;
  int   rx_bits, tail_rises, tail_din_bad, low_bad, prog_rises, acc;
  int   cur_len, done_after, crc_at;
  time  last_fall;

  always #(CLK_T/2) clk = ~clk;

  cfg_serial_loader #(.LEN_W(LW), .DIV(DIV), .TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .len_i(len_i),
    .byte_i(byte_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .prog_o(prog_o), .cclk_o(cclk_o), .din_o(din_o), .init_i(init_i),
    .done_i(done_i), .busy_o(busy_o), .ok_o(ok_o), .timeout_o(timeout_o),
    .fail_o(fail_o), .crc_err_o(crc_err_o));

  // device model: captures bits on serial clock rise
  always @(posedge cclk_o) begin
    rx_sh = {rx_sh[6:0], din_o};
    rx_bits++;
    if (rx_bits <= 8 * cur_len) begin
      if (rx_bits % 8 == 0 && rx_bits / 8 <= 8) rx_mem[rx_bits/8-1] = rx_sh;
    end else begin
      tail_rises++;
      if (!din_o) tail_din_bad++;
      if (done_after > 0 && tail_rises >= done_after) done_i = 1'b1;
    end
    if (crc_at > 0 && rx_bits == crc_at) init_i = 1'b1;
    if (last_fall != 0 && ($time - last_fall) != DIV * CLK_T) low_bad++;
  end
  always @(negedge cclk_o) last_fall = $time;
  always @(posedge prog_o) prog_rises++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic prep(input int len, input int d_after, input int c_at);
    rx_bits = 0; tail_rises = 0; tail_din_bad = 0; low_bad = 0; prog_rises = 0; acc = 0;
    last_fall = 0; cur_len = len; done_after = d_after; crc_at = c_at;
    init_i = 1'b0; done_i = 1'b0;
  endtask

  task automatic do_start(input int len);
    @(negedge clk); len_i = LW'(len); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic handshake();
    while (!prog_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(prog_o == 1'b1, "R2", "prog held before init", int'(prog_o), 1);
    init_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(prog_o == 1'b0, "R3", "prog released after init", int'(prog_o), 0);
    repeat (3) @(negedge clk);
    chk(byte_ready_o == 1'b0, "R3", "no request while init high", int'(byte_ready_o), 0);
    init_i = 1'b0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      byte_i = tx[i]; byte_valid_i = 1'b1;
      @(negedge clk);
      while (!byte_ready_o && busy_o) @(negedge clk);
      if (!busy_o) break;
      @(posedge clk); #1;
      acc++;
    end
    byte_valid_i = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy_o && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset();
    chk({busy_o, prog_o, cclk_o, din_o, byte_ready_o, ok_o, timeout_o, fail_o, crc_err_o} == '0,
        "R1", "idle outputs", int'({busy_o, prog_o, cclk_o, din_o, byte_ready_o}), 0);
  endtask

  task automatic t_normal();
    int c;
    tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h81;
    prep(3, 3, 0);
    do_start(3);
    fork
      feed(3);
      handshake();
      begin repeat (40) @(negedge clk); len_i = 8'd7; start_i = 1'b1; @(negedge clk); start_i = 1'b0; end
    join
    wait_idle(c);
    chk(ok_o == 1'b1, "R7", "success flag", int'(ok_o), 1);
    for (int i = 0; i < 3; i++)
      chk(rx_mem[i] == tx[i], "R4", "byte MSB first", int'(rx_mem[i]), int'(tx[i]));
    chk(acc == 3, "R5", "bytes consumed", acc, 3);
    chk(low_bad == 0, "R4", "low phase width errors", low_bad, 0);
    chk(tail_rises == 3, "R7", "clocks until done", tail_rises, 3);
    chk(tail_din_bad == 0, "R7", "din low in tail", tail_din_bad, 0);
    chk(prog_rises == 1, "R9", "start while busy ignored", prog_rises, 1);
    repeat (10) @(negedge clk);
    chk(ok_o && !busy_o, "R9", "result held while idle", int'(ok_o), 1);
  endtask

  task automatic t_init_timeout();
    int c;
    prep(1, 0, 0);
    do_start(1);
    wait_idle(c);
    chk(timeout_o == 1'b1 && !fail_o, "R2", "init wait timeout", int'(timeout_o), 1);
    chk(c >= TMO - 2 && c <= TMO + 2, "R2", "timeout length", c, TMO);
  endtask

  task automatic t_clear_timeout();
    int c;
    prep(1, 0, 0);
    do_start(1);
    while (!prog_o) @(negedge clk);
    init_i = 1'b1;
    wait_idle(c);
    chk(fail_o == 1'b1 && !timeout_o, "R3", "init clear timeout", int'(fail_o), 1);
    chk(rx_bits == 0, "R3", "no bits sent", rx_bits, 0);
    init_i = 1'b0;
  endtask

  task automatic t_crc();
    int c;
    tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33; tx[3] = 8'h44;
    prep(4, 0, 16);
    do_start(4);
    fork feed(4); handshake(); join
    wait_idle(c);
    chk(crc_err_o == 1'b1, "R6", "load error flag", int'(crc_err_o), 1);
    chk(acc == 2, "R6", "bytes before error", acc, 2);
    chk(rx_bits == 16, "R6", "bits before error", rx_bits, 16);
    init_i = 1'b0;
  endtask

  task automatic t_done_timeout_and_zero();
    int c;
    tx[0] = 8'hF0;
    prep(1, 0, 0);
    do_start(1);
    fork feed(1); handshake(); join
    wait_idle(c);
    chk(fail_o == 1'b1 && !ok_o, "R8", "no done -> fail", int'(fail_o), 1);
    chk(tail_rises > 10 && tail_din_bad == 0, "R8", "tail din high", tail_din_bad, 0);
    chk(rx_mem[0] == 8'hF0, "R4", "single byte", int'(rx_mem[0]), 8'hF0);
    repeat (5) @(negedge clk);
    chk(fail_o == 1'b1, "R9", "fail held", int'(fail_o), 1);
    prep(0, 2, 0);
    do_start(0);
    chk(fail_o == 1'b0 && busy_o, "R9", "start clears result", int'(fail_o), 0);
    handshake();
    wait_idle(c);
    chk(ok_o == 1'b1, "R10", "zero length success", int'(ok_o), 1);
    chk(acc == 0 && rx_bits == 2, "R10", "only tail clocks", rx_bits, 2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_T * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    prep(0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_init_timeout();
    t_clear_timeout();
    t_crc();
    t_done_timeout_and_zero();
    summary();
    $finish;
  end
endmodule